// File: doc/BRIEF.md
# Indirect LCD segment store

This block keeps the on/off state of every segment of a four-common LCD panel in fifteen bytes of flop storage. A host CPU reaches the bytes only indirectly, through a pointer register and a data register on a small register bus. The block also has a configuration register that carries a freeze control. A display-side port picks one common line and gets back the segment pattern for that line, with one bit for each of the thirty segment lines.

Byte N serves segment lines 2N and 2N+1. Its low nibble holds line 2N and its high nibble holds line 2N+1, with one bit for each common inside a nibble. The host moves a byte in one of two ways. It loads the data register and then writes the pointer with the direction bit set. Or it writes the pointer with the direction bit clear and reads the data register one cycle later.

While freeze is set, the display port shows a snapshot of the image. The host can then rebuild the whole image without the panel ever showing a half-finished one. A retention input models a low-power state: during it the storage is kept and all host writes are dropped.

The block has two state machines. The access machine has the states IDLE, WRITE and READ, with these transitions:
- LAUNCH_WR: a pointer write with bit 7 set and a row below 15 moves it to WRITE.
- LAUNCH_RD: a pointer write with bit 7 clear moves it to READ.
- ROW_SKIP: a write-direction pointer to row 15 stays in IDLE.
- DONE: it leaves WRITE or READ after one cycle, to IDLE or to a newly launched access.

The view machine has the states LIVE and HELD, with these transitions:
- FREEZE: a configuration write with bit 0 set moves it to HELD.
- THAW: a configuration write with bit 0 clear moves it to LIVE.

Top module: `segmem_top`

## Requirements
- R1: Each of the 15 rows (0 to 14) stores a full 8-bit value, and a later fetch of that row returns the value written.
- R2: With disp_com = c, disp_seg[2N] equals bit c of row N and disp_seg[2N+1] equals bit 4+c of row N, for every N from 0 to 14.
- R3: Register selects on bus_addr are 0 = pointer, 1 = data, 2 = configuration (bit 0 is freeze) and 3 = reads as 0x00. bus_rdata returns the pointer and data registers exactly as held, and the configuration register as {7'b0, freeze}.
- R4: A pointer write with bit 7 = 1 copies the data register into row ptr[3:0] at the clock edge one cycle after the pointer-write edge.
- R5: A pointer write with bit 7 = 0 loads the data register with row ptr[3:0] at the clock edge one cycle after the pointer-write edge.
- R6: A write-direction pointer to row 15 changes no row. A read-direction pointer to row 15 loads 0x00 into the data register.
- R7: While freeze is 1, disp_seg shows the image that was stored at the edge where freeze was set, even though the rows keep changing. After the edge that clears freeze, disp_seg shows the current rows.
- R8: While retain is 1, writes to any register are ignored, no transfer takes place, and the rows keep their contents.
- R9: Reset clears all rows, the snapshot, the pointer, the data register and freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retain | input | 1 | Low-power retention: host writes ignored, rows kept |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| disp_com | input | 2 | Common line chosen by the display side |
| disp_seg | output | 30 | Segment states for the chosen common |

## Verification
The hardest case to reach is the frozen view. It needs a state in which the rows and the visible image differ. To build it, the bench stores a known image, sets freeze, and rewrites several rows. It then checks every common against the old image while indirect fetches return the new values. After clearing freeze, it checks the new image on the very next sample. The segment packing is swept exhaustively with one hot bit over every row and bit position, and every common line is checked for each placement.

// File: rtl/segmem_pkg.sv
`timescale 1ns/1ps
package segmem_pkg;

    localparam int SEG_ROWS = 15;
    localparam int SEG_COMS = 4;

    localparam logic [1:0] RSEL_PTR  = 2'd0;
    localparam logic [1:0] RSEL_DATA = 2'd1;
    localparam logic [1:0] RSEL_CTRL = 2'd2;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_state_t;

    typedef enum logic {
        VIEW_LIVE = 1'b0,
        VIEW_HELD = 1'b1
    } view_state_t;

endpackage

// File: rtl/segmem_host.sv
`timescale 1ns/1ps
module segmem_host
    import segmem_pkg::*;
#(
    parameter int DW     = 8,
    parameter int AW     = 4,
    parameter int NBYTES = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          retain,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          data_load,
    output logic          freeze
);

    acc_state_t  acc_q, acc_d, launch_st;
    view_state_t view_q, view_d;
    logic [DW-1:0] ptr_q, data_q;

    logic host_ok, ptr_hit, data_hit, ctrl_hit, skip_wr;

    assign host_ok  = bus_wr && !retain;
    assign ptr_hit  = host_ok && (bus_addr == RSEL_PTR);
    assign data_hit = host_ok && (bus_addr == RSEL_DATA);
    assign ctrl_hit = host_ok && (bus_addr == RSEL_CTRL);
    // write direction aimed past the last row: dropped (ROW_SKIP)
    assign skip_wr  = bus_wdata[DW-1] && (bus_wdata[AW-1:0] >= AW'(NBYTES));

    // access launched by this cycle's pointer write
    always_comb begin
        if (!ptr_hit)               launch_st = ACC_IDLE;
        else if (skip_wr)           launch_st = ACC_IDLE;   // ROW_SKIP
        else if (bus_wdata[DW-1])   launch_st = ACC_WRITE;  // LAUNCH_WR
        else                        launch_st = ACC_READ;   // LAUNCH_RD
    end

    always_comb begin
        acc_d = acc_q;
        unique case (acc_q)
            ACC_IDLE:             acc_d = launch_st;
            ACC_WRITE, ACC_READ:  acc_d = launch_st;        // DONE
            default:              acc_d = ACC_IDLE;
        endcase
    end

    always_comb begin
        view_d = view_q;
        unique case (view_q)
            VIEW_LIVE: if (ctrl_hit && bus_wdata[0])  view_d = VIEW_HELD; // FREEZE
            VIEW_HELD: if (ctrl_hit && !bus_wdata[0]) view_d = VIEW_LIVE; // THAW
            default:   view_d = VIEW_LIVE;
        endcase
    end

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= ACC_IDLE;
            view_q <= VIEW_LIVE;
        end else begin
            acc_q  <= acc_d;
            view_q <= view_d;
        end
    end

    // state outputs
    always_comb begin
        mem_we    = 1'b0;
        data_load = 1'b0;
        unique case (acc_q)
            ACC_IDLE:  ;
            ACC_WRITE: mem_we    = !retain;
            ACC_READ:  data_load = !retain;
            default:   ;
        endcase
    end

    assign freeze    = (view_q == VIEW_HELD);
    assign mem_addr  = ptr_q[AW-1:0];
    assign mem_wdata = data_q;

    // host-visible registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            data_q <= '0;
        end else begin
            if (ptr_hit) ptr_q <= bus_wdata;
            if (data_load)     data_q <= mem_rdata;
            else if (data_hit) data_q <= bus_wdata;
        end
    end

    always_comb begin
        unique case (bus_addr)
            RSEL_PTR:  bus_rdata = ptr_q;
            RSEL_DATA: bus_rdata = data_q;
            RSEL_CTRL: bus_rdata = {{(DW-1){1'b0}}, freeze};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/segmem_store.sv
`timescale 1ns/1ps
module segmem_store #(
    parameter int DW     = 8,
    parameter int AW     = 4,
    parameter int NBYTES = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic                 freeze,
    output logic [NBYTES*DW-1:0] live_flat,
    output logic [NBYTES*DW-1:0] held_flat
);

    logic [DW-1:0] row_q  [NBYTES];
    logic [DW-1:0] snap_q [NBYTES];

    for (genvar i = 0; i < NBYTES; i++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              row_q[i] <= '0;
            else if (we && (addr == AW'(i)))         row_q[i] <= wdata;
        end

        // snapshot follows the rows whenever the view is live
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       snap_q[i] <= '0;
            else if (!freeze) snap_q[i] <= row_q[i];
        end

        assign live_flat[i*DW +: DW] = row_q[i];
        assign held_flat[i*DW +: DW] = snap_q[i];
    end

    // indirect read port; rows past the end read as zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (addr == AW'(i)) rdata = row_q[i];
        end
    end

endmodule

// File: rtl/segmem_view.sv
`timescale 1ns/1ps
module segmem_view #(
    parameter int NCOM   = 4,
    parameter int NBYTES = 15,
    localparam int DW    = 2 * NCOM,
    localparam int CW    = $clog2(NCOM)
) (
    input  logic                 freeze,
    input  logic [NBYTES*DW-1:0] live_flat,
    input  logic [NBYTES*DW-1:0] held_flat,
    input  logic [CW-1:0]        com,
    output logic [2*NBYTES-1:0]  seg
);

    logic [NBYTES*DW-1:0] frame;

    assign frame = freeze ? held_flat : live_flat;

    for (genvar n = 0; n < NBYTES; n++) begin : g_pair
        logic [DW-1:0] byte_v;
        assign byte_v       = frame[n*DW +: DW];
        assign seg[2*n]     = byte_v[com];                 // even line, low nibble
        assign seg[2*n + 1] = byte_v[NCOM + int'(com)];    // odd line, high nibble
    end

endmodule

// File: rtl/segmem_top.sv
`timescale 1ns/1ps
module segmem_top
    import segmem_pkg::*;
#(
    parameter int NBYTES = SEG_ROWS,
    parameter int NCOM   = SEG_COMS,
    localparam int DW    = 2 * NCOM,
    localparam int AW    = $clog2(NBYTES + 1),
    localparam int CW    = $clog2(NCOM),
    localparam int NSEG  = 2 * NBYTES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            retain,
    input  logic            bus_wr,
    input  logic [1:0]      bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [CW-1:0]   disp_com,
    output logic [NSEG-1:0] disp_seg
);

    logic                 mem_we, data_load, freeze;
    logic [AW-1:0]        mem_addr;
    logic [DW-1:0]        mem_wdata, mem_rdata;
    logic [NBYTES*DW-1:0] live_flat, held_flat;

    segmem_host #(.DW(DW), .AW(AW), .NBYTES(NBYTES)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .retain    (retain),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .data_load (data_load),
        .freeze    (freeze)
    );

    segmem_store #(.DW(DW), .AW(AW), .NBYTES(NBYTES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (mem_we),
        .addr      (mem_addr),
        .wdata     (mem_wdata),
        .rdata     (mem_rdata),
        .freeze    (freeze),
        .live_flat (live_flat),
        .held_flat (held_flat)
    );

    segmem_view #(.NCOM(NCOM), .NBYTES(NBYTES)) u_view (
        .freeze    (freeze),
        .live_flat (live_flat),
        .held_flat (held_flat),
        .com       (disp_com),
        .seg       (disp_seg)
    );

endmodule

// File: rtl/segmem_chk.sv
`timescale 1ns/1ps
module segmem_chk #(
    parameter int DW     = 8,
    parameter int AW     = 4,
    parameter int NBYTES = 15
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 retain,
    input logic                 bus_wr,
    input logic [1:0]           bus_addr,
    input logic [DW-1:0]        bus_wdata,
    input logic                 mem_we,
    input logic                 data_load,
    input logic [AW-1:0]        mem_addr,
    input logic                 freeze,
    input logic [NBYTES*DW-1:0] live_flat,
    input logic [NBYTES*DW-1:0] held_flat
);

    logic launch_ok;
    assign launch_ok = bus_wr && !retain && (bus_addr == 2'd0) &&
                       !(bus_wdata[DW-1] && (bus_wdata[AW-1:0] >= AW'(NBYTES)));

    AST_XFER_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        launch_ok |=> (retain || mem_we || data_load));                 // R4
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, data_load}));                                 // R5
    AST_NO_ROW15: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr < AW'(NBYTES)));                           // R6
    AST_FROZEN_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> (!freeze || $stable(held_flat)));                    // R7
    AST_RETAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        retain |=> $stable(live_flat));                                 // R8

endmodule

bind segmem_top segmem_chk #(.DW(DW), .AW(AW), .NBYTES(NBYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .retain    (retain),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mem_we    (mem_we),
    .data_load (data_load),
    .mem_addr  (mem_addr),
    .freeze    (freeze),
    .live_flat (live_flat),
    .held_flat (held_flat)
);

// File: tb/segmem_top_test.sv
`timescale 1ns/1ps
module segmem_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retain = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [1:0]  disp_com = 2'd0;
    logic [29:0] disp_seg;

    int vectors = 0;
    int misses  = 0;
    logic [7:0] model [15];
    logic [7:0] snap  [15];

    segmem_top uut (
        .clk(clk), .rst_n(rst_n), .retain(retain), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .disp_com(disp_com), .disp_seg(disp_seg)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_put(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic store_row(input int a, input logic [7:0] v);
        bus_put(2'd1, v);
        bus_put(2'd0, 8'h80 | 8'(a));
        @(negedge clk);              // transfer edge has passed
        if (a < 15) model[a] = v;
    endtask

    task automatic fetch_row(input int a, output logic [7:0] v);
        bus_put(2'd0, 8'(a));
        @(negedge clk);
        bus_addr = 2'd1;
        #1 v = bus_rdata;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    function automatic logic [29:0] expect_seg(input logic [7:0] img [15], input int c);
        logic [29:0] s;
        for (int n = 0; n < 15; n++) begin
            s[2*n]   = (img[n] >> c) & 1'b1;
            s[2*n+1] = (img[n] >> (4 + c)) & 1'b1;
        end
        return s;
    endfunction

    task automatic check_view(input string req, input logic [7:0] img [15]);
        for (int c = 0; c < 4; c++) begin
            disp_com = 2'(c);
            #1 check(req, 32'(disp_seg), 32'(expect_seg(img, c)));
        end
    endtask

    initial begin : watchdog
        #(20 * 150000);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        for (int i = 0; i < 15; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        for (int r = 0; r < 4; r++) begin
            read_reg(2'(r), v);
            check("R9 reset register", 32'(v), 32'h0);
        end
        check_view("R9 reset image", model);

        // R1 R4 R5: fill every row, fetch all 16 addresses
        for (int a = 0; a < 15; a++) store_row(a, 8'((a * 37 + 11) ^ 8'h5A));
        for (int a = 0; a < 16; a++) begin
            fetch_row(a, v);
            if (a < 15) check("R1 R4 R5 row fetch", 32'(v), 32'(model[a]));
            else        check("R6 row15 fetch zero", 32'(v), 32'h0);
        end
        check_view("R2 patterned image", model);

        // R2: one-hot sweep over every row and bit
        for (int a = 0; a < 15; a++) store_row(a, 8'h00);
        for (int a = 0; a < 15; a++) begin
            for (int b = 0; b < 8; b++) begin
                store_row(a, 8'(1 << b));
                check_view("R2 one-hot packing", model);
            end
            store_row(a, 8'h00);
        end

        // R6: write aimed at row 15 is dropped
        for (int a = 0; a < 15; a++) store_row(a, 8'(a + 8'h30));
        store_row(15, 8'hFF);
        check_view("R6 row15 write ignored", model);
        fetch_row(15, v);
        check("R6 row15 read zero", 32'(v), 32'h0);

        // R3: register readback
        bus_put(2'd0, 8'h75);
        read_reg(2'd0, v);  check("R3 pointer readback", 32'(v), 32'h75);
        @(negedge clk);
        bus_put(2'd1, 8'hC3);
        read_reg(2'd1, v);  check("R3 data readback", 32'(v), 32'hC3);
        bus_put(2'd3, 8'hFF);
        read_reg(2'd3, v);  check("R3 unused select", 32'(v), 32'h0);
        read_reg(2'd2, v);  check("R3 config idle", 32'(v), 32'h0);

        // R7: freeze holds the image while rows change
        for (int a = 0; a < 15; a++) snap[a] = model[a];
        bus_put(2'd2, 8'h01);
        read_reg(2'd2, v);  check("R3 config freeze bit", 32'(v), 32'h1);
        store_row(0, 8'hA5);
        store_row(7, 8'h3C);
        store_row(14, 8'hFF);
        check_view("R7 frozen image", snap);
        fetch_row(7, v);
        check("R7 rows update while frozen", 32'(v), 32'h3C);
        bus_put(2'd2, 8'h00);
        check_view("R7 thawed image", model);

        // R8: retention drops every host write
        @(negedge clk);
        retain = 1'b1;
        bus_put(2'd1, 8'h99);
        bus_put(2'd0, 8'h83);
        bus_put(2'd2, 8'h01);
        @(negedge clk);
        read_reg(2'd1, v);  check("R8 data unchanged", 32'(v), 32'h3C);
        read_reg(2'd0, v);  check("R8 pointer unchanged", 32'(v), 32'h07);
        read_reg(2'd2, v);  check("R8 freeze unchanged", 32'(v), 32'h0);
        check_view("R8 rows retained", model);
        @(negedge clk);
        retain = 1'b0;
        fetch_row(3, v);
        check("R8 row after retain", 32'(v), 32'(model[3]));

        // R9: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        for (int i = 0; i < 15; i++) model[i] = 8'h00;
        check_view("R9 image cleared", model);
        @(negedge clk);
        rst_n = 1'b1;
        read_reg(2'd1, v);  check("R9 data cleared", 32'(v), 32'h0);
        fetch_row(9, v);    check("R9 row cleared", 32'(v), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule